// File: doc/BRIEF.md
# Operand-Selecting Eight-Function ALU

This block is the combinational arithmetic and logic stage of a 32-bit datapath slice. Four 32-bit candidate values reach it from outside: the first and second read ports of a register file, an accumulator register, and a direct data bus. A 3-bit source code picks two operands, R and S, from those candidates or from a constant zero. A 3-bit function code then applies one of three arithmetic or five bitwise operations, with a single carry input feeding the arithmetic ones.

The result appears on a 32-bit output together with four status bits: sign, zero, signed overflow and carry out. The stage holds no state. The register file, the accumulator, any shifting and any write-back sit outside it and read its outputs in the same cycle. The data here is a plain combinational path with no transfer and no back-pressure, so it carries no valid/ready handshake. All pins are plain control, data or status.

Top module: `opsel_alu`

## Requirements
- R1: The source code selects (R,S) as 0=(A,Q), 1=(A,B), 2=(0,Q), 3=(0,B), 4=(0,A), 5=(D,A), 6=(D,Q), 7=(D,0). Here A is `a_port`, B is `b_port`, Q is `q_reg` and D is `d_in`.
- R2: Function code 0 gives F = R + S + carry_in, modulo 2^32.
- R3: Function code 1 gives F = S + NOT(R) + carry_in. This equals S − R when carry_in is 1 and S − R − 1 when carry_in is 0.
- R4: Function code 2 gives F = R + NOT(S) + carry_in. This equals R − S when carry_in is 1 and R − S − 1 when carry_in is 0.
- R5: Function codes 3, 4, 5, 6 and 7 give, in that order, R OR S, R AND S, (NOT R) AND S, R XOR S and R XNOR S.
- R6: For function codes 3 to 7, carry_in has no effect on F.
- R7: sign_out equals bit 31 of F.
- R8: zero_out is 1 exactly when all 32 bits of F are 0.
- R9: For function codes 0 to 2, ovr_out is 1 exactly when the signed (two's-complement) value of the operation lies outside −2^31 … 2^31−1.
- R10: For function codes 0 to 2, carry_out is bit 32 of the 33-bit unsigned sum of the two adder inputs and carry_in.
- R11: For function codes 3 to 7, carry_out and ovr_out are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_sel | input | 3 | Operand pair code (R1) |
| func_sel | input | 3 | Operation code (R2–R5) |
| carry_in | input | 1 | Carry into the adder LSB |
| a_port | input | 32 | Register file first read port |
| b_port | input | 32 | Register file second read port |
| q_reg | input | 32 | Accumulator register value |
| d_in | input | 32 | Direct data bus |
| f_out | output | 32 | Result F |
| sign_out | output | 1 | Most significant bit of F |
| zero_out | output | 1 | High when F is all zeros |
| ovr_out | output | 1 | Signed overflow of arithmetic operations |
| carry_out | output | 1 | Carry out of the most significant bit |

## Verification
The block holds no state, so a fault inside it shows at the ports in the same evaluation as the inputs that expose it. A wrong operand routing or a swapped subtraction direction changes F straight away, for some source code or function code. A wrong carry into the top bit shows only on overflow and carry out, and only with operands near the signed and unsigned limits. For that reason the sweep covers every source code, every function code and both carry values over operand sets that include all zeros, all ones, and the most positive and most negative values.

// File: rtl/opsel_alu_pkg.sv
package opsel_alu_pkg;

  localparam int unsigned ALU_W = 32;

  typedef enum logic [2:0] {
    SRC_A_Q = 3'd0,
    SRC_A_B = 3'd1,
    SRC_Z_Q = 3'd2,
    SRC_Z_B = 3'd3,
    SRC_Z_A = 3'd4,
    SRC_D_A = 3'd5,
    SRC_D_Q = 3'd6,
    SRC_D_Z = 3'd7
  } src_code_e;

  typedef enum logic [2:0] {
    FN_ADD       = 3'd0,
    FN_S_MINUS_R = 3'd1,
    FN_R_MINUS_S = 3'd2,
    FN_OR        = 3'd3,
    FN_AND       = 3'd4,
    FN_NOTR_AND  = 3'd5,
    FN_XOR       = 3'd6,
    FN_XNOR      = 3'd7
  } fn_code_e;

  typedef enum logic [1:0] {
    RSEL_A, RSEL_D, RSEL_ZERO
  } r_pick_e;

  typedef enum logic [1:0] {
    SSEL_A, SSEL_B, SSEL_Q, SSEL_ZERO
  } s_pick_e;

endpackage

// File: rtl/opsel_operand_mux.sv
module opsel_operand_mux
  import opsel_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  src_code_e      src,
  input  logic [W-1:0]   a_val,
  input  logic [W-1:0]   b_val,
  input  logic [W-1:0]   q_val,
  input  logic [W-1:0]   d_val,
  output logic [W-1:0]   r_op,
  output logic [W-1:0]   s_op
);

  r_pick_e r_pick;
  s_pick_e s_pick;

  // Decode the source code into independent R and S picks.
  always_comb begin
    unique case (src)
      SRC_A_Q: begin r_pick = RSEL_A;    s_pick = SSEL_Q;    end
      SRC_A_B: begin r_pick = RSEL_A;    s_pick = SSEL_B;    end
      SRC_Z_Q: begin r_pick = RSEL_ZERO; s_pick = SSEL_Q;    end
      SRC_Z_B: begin r_pick = RSEL_ZERO; s_pick = SSEL_B;    end
      SRC_Z_A: begin r_pick = RSEL_ZERO; s_pick = SSEL_A;    end
      SRC_D_A: begin r_pick = RSEL_D;    s_pick = SSEL_A;    end
      SRC_D_Q: begin r_pick = RSEL_D;    s_pick = SSEL_Q;    end
      default: begin r_pick = RSEL_D;    s_pick = SSEL_ZERO; end
    endcase
  end

  always_comb begin
    unique case (r_pick)
      RSEL_A:  r_op = a_val;
      RSEL_D:  r_op = d_val;
      default: r_op = '0;
    endcase
  end

  always_comb begin
    unique case (s_pick)
      SSEL_A:  s_op = a_val;
      SSEL_B:  s_op = b_val;
      SSEL_Q:  s_op = q_val;
      default: s_op = '0;
    endcase
  end

  always_comb begin
    // R1
    src_r_zero_chk: assert (!(src inside {SRC_Z_Q, SRC_Z_B, SRC_Z_A}) || r_op == '0)
      else $error("R operand not zero for zero-R source code");
    // R1
    src_s_zero_chk: assert (src != SRC_D_Z || s_op == '0)
      else $error("S operand not zero for D,0 source code");
  end

endmodule

// File: rtl/opsel_alu_core.sv
module opsel_alu_core
  import opsel_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  fn_code_e       fn,
  input  logic           cin,
  input  logic [W-1:0]   r_op,
  input  logic [W-1:0]   s_op,
  output logic [W-1:0]   f,
  output logic           cout,
  output logic           ovr
);

  localparam int unsigned MSB = W - 1;

  logic [W-1:0] add_x;
  logic [W-1:0] add_y;
  logic [W:0]   full_sum;
  logic [W-1:0] low_sum;
  logic         carry_into_msb;
  logic         is_arith;
  logic [W-1:0] logic_f;

  assign is_arith = (fn == FN_ADD) || (fn == FN_S_MINUS_R) || (fn == FN_R_MINUS_S);

  // Adder operand steering: subtraction = minuend + ~subtrahend + cin.
  always_comb begin
    unique case (fn)
      FN_S_MINUS_R: begin add_x = s_op; add_y = ~r_op; end
      FN_R_MINUS_S: begin add_x = r_op; add_y = ~s_op; end
      default:      begin add_x = r_op; add_y = s_op;  end
    endcase
  end

  assign full_sum = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, cin};
  assign low_sum  = {1'b0, add_x[MSB-1:0]} + {1'b0, add_y[MSB-1:0]} + {{(W-1){1'b0}}, cin};
  assign carry_into_msb = low_sum[MSB];

  always_comb begin
    unique case (fn)
      FN_OR:       logic_f = r_op | s_op;
      FN_AND:      logic_f = r_op & s_op;
      FN_NOTR_AND: logic_f = ~r_op & s_op;
      FN_XOR:      logic_f = r_op ^ s_op;
      FN_XNOR:     logic_f = ~(r_op ^ s_op);
      default:     logic_f = '0;
    endcase
  end

  assign f    = is_arith ? full_sum[W-1:0] : logic_f;
  assign cout = is_arith & full_sum[W];
  assign ovr  = is_arith & (full_sum[W] ^ carry_into_msb);

  always_comb begin
    // R9
    add_overflow_chk: assert (!is_arith ||
        ovr == ((add_x[MSB] == add_y[MSB]) && (f[MSB] != add_x[MSB])))
      else $error("overflow disagrees with operand and result signs");
    // R11
    logic_flags_low_chk: assert (is_arith || (!cout && !ovr))
      else $error("carry or overflow set in a logic function");
    // R5
    and_subset_chk: assert (fn != FN_AND || (f & ~s_op) == '0)
      else $error("AND result has bits outside S");
    // R5
    or_superset_chk: assert (fn != FN_OR || (f & r_op) == r_op)
      else $error("OR result lost bits of R");
  end

endmodule

// File: rtl/opsel_status.sv
module opsel_status #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] f,
  output logic         sign,
  output logic         zero
);

  assign sign = f[W-1];
  assign zero = ~|f;

  always_comb begin
    // R8
    zero_sign_chk: assert (!zero || !sign)
      else $error("zero flag set while sign flag is set");
  end

endmodule

// File: rtl/opsel_alu.sv
module opsel_alu
  import opsel_alu_pkg::*;
#(
  parameter int unsigned W = ALU_W
) (
  input  logic [2:0]   src_sel,
  input  logic [2:0]   func_sel,
  input  logic         carry_in,
  input  logic [W-1:0] a_port,
  input  logic [W-1:0] b_port,
  input  logic [W-1:0] q_reg,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] f_out,
  output logic         sign_out,
  output logic         zero_out,
  output logic         ovr_out,
  output logic         carry_out
);

  logic [W-1:0] r_op;
  logic [W-1:0] s_op;
  src_code_e    src;
  fn_code_e     fn;

  assign src = src_code_e'(src_sel);
  assign fn  = fn_code_e'(func_sel);

  opsel_operand_mux #(.W(W)) u_mux (
    .src   (src),
    .a_val (a_port),
    .b_val (b_port),
    .q_val (q_reg),
    .d_val (d_in),
    .r_op  (r_op),
    .s_op  (s_op)
  );

  opsel_alu_core #(.W(W)) u_core (
    .fn   (fn),
    .cin  (carry_in),
    .r_op (r_op),
    .s_op (s_op),
    .f    (f_out),
    .cout (carry_out),
    .ovr  (ovr_out)
  );

  opsel_status #(.W(W)) u_status (
    .f    (f_out),
    .sign (sign_out),
    .zero (zero_out)
  );

endmodule

// File: tb/tb_opsel_alu.sv
module tb_opsel_alu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  src_sel = '0;
  logic [2:0]  func_sel = '0;
  logic        carry_in = 1'b0;
  logic [31:0] a_port = '0, b_port = '0, q_reg = '0, d_in = '0;
  logic [31:0] f_out;
  logic        sign_out, zero_out, ovr_out, carry_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  opsel_alu dut (
    .src_sel(src_sel), .func_sel(func_sel), .carry_in(carry_in),
    .a_port(a_port), .b_port(b_port), .q_reg(q_reg), .d_in(d_in),
    .f_out(f_out), .sign_out(sign_out), .zero_out(zero_out),
    .ovr_out(ovr_out), .carry_out(carry_out)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (src=%0d fn=%0d cin=%0d)",
               tag, act, exp, src_sel, func_sel, carry_in);
    end
  endtask

  function automatic logic [31:0] mix(input int k, input logic [31:0] salt);
    return (32'(k) * 32'h9E37_79B9) ^ salt;
  endfunction

  task automatic run_one(input int src, input int fn, input bit cin);
    logic [31:0] r, s, ef;
    longint unsigned ur, us, tot;
    longint sr, ss, st;
    bit eovr, ecout, arith;
    string ftag;
    src_sel = 3'(src); func_sel = 3'(fn); carry_in = cin;
    @(negedge clk);
    // R1 operand pairs
    case (src)
      0: begin r = a_port; s = q_reg;  end
      1: begin r = a_port; s = b_port; end
      2: begin r = '0;     s = q_reg;  end
      3: begin r = '0;     s = b_port; end
      4: begin r = '0;     s = a_port; end
      5: begin r = d_in;   s = a_port; end
      6: begin r = d_in;   s = q_reg;  end
      default: begin r = d_in; s = '0; end
    endcase
    ur = longint'(r); us = longint'(s);
    sr = longint'($signed(r)); ss = longint'($signed(s));
    arith = (fn < 3);
    tot = 0; st = 0;
    ef = '0;
    case (fn)
      0: begin tot = ur + us + cin; st = sr + ss + cin; ftag = "R1 R2 add"; end
      1: begin tot = us + (64'hFFFF_FFFF - ur) + cin; st = ss - sr - 1 + cin; ftag = "R1 R3 s-minus-r"; end
      2: begin tot = ur + (64'hFFFF_FFFF - us) + cin; st = sr - ss - 1 + cin; ftag = "R1 R4 r-minus-s"; end
      3: begin ef = r | s;    ftag = "R5 R6 or";   end
      4: begin ef = r & s;    ftag = "R5 R6 and";  end
      5: begin ef = ~r & s;   ftag = "R5 R6 notr-and"; end
      6: begin ef = r ^ s;    ftag = "R5 R6 xor";  end
      default: begin ef = ~(r ^ s); ftag = "R5 R6 xnor"; end
    endcase
    if (arith) begin
      ef    = tot[31:0];
      ecout = tot[32];
      eovr  = (st > 64'sd2147483647) || (st < -64'sd2147483648);
    end else begin
      ecout = 1'b0;
      eovr  = 1'b0;
    end
    check(f_out == ef, ftag, longint'(f_out), longint'(ef));
    check(sign_out == ef[31], "R7 sign", longint'(sign_out), longint'(ef[31]));
    check(zero_out == (ef == 32'd0), "R8 zero", longint'(zero_out), longint'(ef == 32'd0));
    if (arith) begin
      check(ovr_out == eovr, "R9 overflow", longint'(ovr_out), longint'(eovr));
      check(carry_out == ecout, "R10 carry", longint'(carry_out), longint'(ecout));
    end else begin
      check(ovr_out == 1'b0 && carry_out == 1'b0, "R11 logic flags",
            longint'({ovr_out, carry_out}), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // Initial all-zero operands: add gives zero with zero flag (R2, R8)
    @(negedge clk);
    check(f_out == 32'd0 && zero_out, "R8 initial zero", longint'(f_out), 0);
    for (int k = 0; k < 10; k++) begin
      case (k)
        0: begin a_port = 32'h0;         b_port = 32'h0;         q_reg = 32'h0;         d_in = 32'h0;         end
        1: begin a_port = 32'hFFFF_FFFF; b_port = 32'hFFFF_FFFF; q_reg = 32'hFFFF_FFFF; d_in = 32'hFFFF_FFFF; end
        2: begin a_port = 32'h7FFF_FFFF; b_port = 32'h8000_0000; q_reg = 32'h0000_0001; d_in = 32'hFFFF_FFFF; end
        3: begin a_port = 32'h8000_0000; b_port = 32'h7FFF_FFFF; q_reg = 32'hFFFF_FFFF; d_in = 32'h0000_0001; end
        4: begin a_port = 32'h8000_0000; b_port = 32'h8000_0000; q_reg = 32'h7FFF_FFFF; d_in = 32'h7FFF_FFFF; end
        5: begin a_port = 32'h0000_0001; b_port = 32'h0000_0000; q_reg = 32'h8000_0000; d_in = 32'h0000_0000; end
        default: begin
          a_port = mix(k, 32'h1234_5678); b_port = mix(k, 32'hDEAD_BEEF);
          q_reg  = mix(k, 32'h0F0F_F0F0); d_in   = mix(k, 32'hA5A5_5A5A);
        end
      endcase
      for (int src = 0; src < 8; src++)
        for (int fn = 0; fn < 8; fn++)
          for (int c = 0; c < 2; c++)
            run_one(src, fn, c[0]);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule